// File: doc/BRIEF.md
# Fusable Event Counter Bank

This block holds a bank of event counters arranged as adjacent pairs. Each counter has a 64-bit control register and a 48-bit count register. Every cycle, an enabled counter adds a 4-bit increment, taken from its own slice of the increment bus, to its count. The low counter of a pair is the even one and the high counter is the odd one. When the odd counter's control register holds the fusion event code with its enable bit set, the two counters become one 64-bit counter. The two 4-bit slices then form a single 8-bit increment per cycle. The odd counter's count register carries the top 16 bits of the fused value.

Software reaches all registers through a plain write port and a registered read port. The even counter's count address gives a 64-bit view of a fused pair. A write to that address loads only the low 48 bits. A write to the odd counter's count address loads the high part. Each counter has a sticky overflow flag. Writing that counter's count register clears the flag.

The block has no streaming data path. The register port and the increment inputs are plain signals with no handshake. An increment is consumed on every clock edge, and a write takes effect on the edge at which `reg_wr_en` is high.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, all control and count registers, all overflow flags and `reg_rdata` are zero.
- R2: The control register of counter n is at address 2n and its count register is at address 2n+1. `reg_rdata` shows the register addressed at the previous clock edge. A control write stores all 64 bits.
- R3: An address of 2*NUM_CTR or above reads as zero, and a write to such an address changes no register.
- R4: An unfused counter whose control bit 22 (enable) is set adds its 4-bit increment each cycle, modulo 2^48. The increment for counter n is `inc_i[4n+3:4n]`. A counter with bit 22 clear holds its value.
- R5: A pair is fused exactly when the odd counter's control register has bits 35:32 equal to 4'hF, bits 7:0 equal to 8'hFF, and bit 22 set. The state of all other bits has no effect. The enabled fusion word is 64'h0000_000F_0040_00FF.
- R6: In a fused pair, the 64-bit value increases each cycle by {odd increment, even increment} as an 8-bit number. This happens only while the even counter's bit 22 is set. The odd counter's own increment is not added to its count on its own.
- R7: In a fused pair, a carry out of bit 47 of the even count reaches the low 16 bits of the odd count in the same cycle.
- R8: In a fused pair, reading the even count address returns {odd count[15:0], even count[47:0]}. Writing that address loads only the even count from `reg_wdata[47:0]`. Writing the odd count address loads the odd count from `reg_wdata[47:0]`, and its low 16 bits are the high part of the fused value.
- R9: `ovf_o[n]` is set when the 48-bit count of an unfused counter n wraps, or when the 64-bit value of a fused pair whose even counter is n wraps. A wrap of the low 48 bits inside a fused pair does not set the flag. The flag stays set until its own count register is written, and that write clears it.
- R10: A count write in the same cycle as an increment leaves the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_i | input | NUM_CTR*INC_W | Per-cycle increments, counter n in slice n |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| ovf_o | output | NUM_CTR | Sticky overflow flags, one per counter |

## Verification
The hardest states to reach from the ports are the carry from the low 48 bits into the high part and the full 64-bit wrap of a fused pair. Counting from zero would take far too many cycles to reach either one. The stimulus reaches them through the split register view. It preloads the low part and the high part separately, just below the boundary, then applies one cycle of increment and reads both views back. Every pair is fused in turn. The increment slices are swept through many value combinations. Near-miss control words, such as one with the enable bit clear or one with a wrong upper nibble, check that fusion depends only on the fields that define it.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int CTL_W      = 64;
  localparam int EN_BIT     = 22;
  localparam int CODE_W     = 12;
  localparam logic [CODE_W-1:0] FUSE_CODE = 12'hFFF;

  typedef logic [CTL_W-1:0] ctl_t;

  function automatic logic [CODE_W-1:0] evt_code(input ctl_t c);
    return {c[35:32], c[7:0]};
  endfunction

  function automatic logic is_fuse(input ctl_t c);
    return (evt_code(c) == FUSE_CODE) && c[EN_BIT];
  endfunction
endpackage

// File: rtl/evt_ctr_pair.sv
module evt_ctr_pair
  import evt_ctr_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int HI_W  = 16,
  parameter int INC_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 ctl_we,
  input  logic [1:0]                 cnt_we,
  input  logic [CTL_W-1:0]           wdata,
  input  logic [INC_W-1:0]           inc_even,
  input  logic [INC_W-1:0]           inc_odd,
  output logic [1:0][CTL_W-1:0]      ctl_q,
  output logic [1:0][CNT_W-1:0]      cnt_q,
  output logic                       fused,
  output logic [1:0]                 ovf
);
  localparam int STEP_W = 2 * INC_W;

  logic              en_e, en_o;
  logic [STEP_W-1:0] step_e;
  logic [CNT_W:0]    sum_e, sum_o;
  logic [HI_W:0]     hi_sum;
  logic [CNT_W-1:0]  nxt_o;
  logic              wrap_e, wrap_o;

  always_comb begin
    fused  = is_fuse(ctl_q[1]);
    en_e   = ctl_q[0][EN_BIT];
    en_o   = ctl_q[1][EN_BIT];
    step_e = fused ? {inc_odd, inc_even} : {{INC_W{1'b0}}, inc_even};
    sum_e  = en_e ? ({1'b0, cnt_q[0]} + (CNT_W+1)'(step_e)) : {1'b0, cnt_q[0]};
    hi_sum = {1'b0, cnt_q[1][HI_W-1:0]} + (HI_W+1)'(sum_e[CNT_W]);
    sum_o  = en_o ? ({1'b0, cnt_q[1]} + (CNT_W+1)'(inc_odd)) : {1'b0, cnt_q[1]};
    if (fused) begin
      nxt_o  = {cnt_q[1][CNT_W-1:HI_W], hi_sum[HI_W-1:0]};
      wrap_e = hi_sum[HI_W] & ~cnt_we[1];
      wrap_o = 1'b0;
    end else begin
      nxt_o  = sum_o[CNT_W-1:0];
      wrap_e = sum_e[CNT_W];
      wrap_o = sum_o[CNT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
      ovf   <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (ctl_we[i]) ctl_q[i] <= wdata;
      end
      cnt_q[0] <= cnt_we[0] ? wdata[CNT_W-1:0] : sum_e[CNT_W-1:0];
      cnt_q[1] <= cnt_we[1] ? wdata[CNT_W-1:0] : nxt_o;
      ovf[0]   <= cnt_we[0] ? 1'b0 : (ovf[0] | wrap_e);
      ovf[1]   <= cnt_we[1] ? 1'b0 : (ovf[1] | wrap_o);
    end
  end
endmodule

// File: rtl/evt_ctr_rdmux.sv
module evt_ctr_rdmux
  import evt_ctr_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int CNT_W     = 48,
  parameter int HI_W      = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [2*NUM_PAIRS-1:0][CTL_W-1:0]   ctl_q,
  input  logic [2*NUM_PAIRS-1:0][CNT_W-1:0]   cnt_q,
  input  logic [NUM_PAIRS-1:0]                fused,
  output logic [CTL_W-1:0]                    rdata
);
  localparam int NUM_CTR = 2 * NUM_PAIRS;

  logic [CTL_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (addr == ADDR_W'(2 * n)) sel = ctl_q[n];
    end
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (addr == ADDR_W'(4 * p + 1)) begin
        if (fused[p]) sel = CTL_W'({cnt_q[2*p+1][HI_W-1:0], cnt_q[2*p]});
        else          sel = CTL_W'(cnt_q[2*p]);
      end
      if (addr == ADDR_W'(4 * p + 3)) sel = CTL_W'(cnt_q[2*p+1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= sel;
  end
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int INC_W     = 4,
  parameter int CNT_W     = 48,
  parameter int HI_W      = 16,
  parameter int ADDR_W    = $clog2(4 * NUM_PAIRS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2*NUM_PAIRS*INC_W-1:0] inc_i,
  input  logic                         reg_wr_en,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [CTL_W-1:0]             reg_wdata,
  output logic [CTL_W-1:0]             reg_rdata,
  output logic [2*NUM_PAIRS-1:0]       ovf_o
);
  localparam int NUM_CTR = 2 * NUM_PAIRS;

  logic [NUM_CTR-1:0]            ctl_we, cnt_we;
  logic [NUM_CTR-1:0][CTL_W-1:0] ctl_q;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_PAIRS-1:0]          fused;

  always_comb begin
    for (int n = 0; n < NUM_CTR; n++) begin
      ctl_we[n] = reg_wr_en && (reg_addr == ADDR_W'(2 * n));
      cnt_we[n] = reg_wr_en && (reg_addr == ADDR_W'(2 * n + 1));
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    evt_ctr_pair #(.CNT_W(CNT_W), .HI_W(HI_W), .INC_W(INC_W)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we[2*p+1:2*p]),
      .cnt_we   (cnt_we[2*p+1:2*p]),
      .wdata    (reg_wdata),
      .inc_even (inc_i[(2*p)*INC_W +: INC_W]),
      .inc_odd  (inc_i[(2*p+1)*INC_W +: INC_W]),
      .ctl_q    (ctl_q[2*p+1:2*p]),
      .cnt_q    (cnt_q[2*p+1:2*p]),
      .fused    (fused[p]),
      .ovf      (ovf_o[2*p+1:2*p])
    );
  end

  evt_ctr_rdmux #(.NUM_PAIRS(NUM_PAIRS), .CNT_W(CNT_W), .HI_W(HI_W), .ADDR_W(ADDR_W)) u_rdmux (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (reg_addr),
    .ctl_q (ctl_q),
    .cnt_q (cnt_q),
    .fused (fused),
    .rdata (reg_rdata)
  );
endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk
  import evt_ctr_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int CNT_W     = 48,
  parameter int ADDR_W    = 4
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                reg_wr_en,
  input logic [ADDR_W-1:0]                   reg_addr,
  input logic [CTL_W-1:0]                    reg_wdata,
  input logic [CTL_W-1:0]                    reg_rdata,
  input logic [2*NUM_PAIRS-1:0]              ovf_o,
  input logic [2*NUM_PAIRS-1:0][CTL_W-1:0]   ctl_q,
  input logic [2*NUM_PAIRS-1:0][CNT_W-1:0]   cnt_q
);
  localparam int NUM_CTR = 2 * NUM_PAIRS;

  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= 2 * NUM_CTR) |=> (reg_rdata == '0));

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_chk
    // R2
    ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(2 * n)) |=> (ctl_q[n] == $past(reg_wdata)));
    // R10
    cnt_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(2 * n + 1)) |=> (cnt_q[n] == $past(reg_wdata[CNT_W-1:0])));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[n][EN_BIT] && !(reg_wr_en && reg_addr == ADDR_W'(2 * n + 1))) |=> $stable(cnt_q[n]));
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o[n] && !(reg_wr_en && reg_addr == ADDR_W'(2 * n + 1))) |=> ovf_o[n]);
    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(2 * n + 1)) |=> !ovf_o[n]);
  end
endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(.NUM_PAIRS(NUM_PAIRS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .ovf_o     (ovf_o),
  .ctl_q     (ctl_q),
  .cnt_q     (cnt_q)
);

// File: tb/evt_ctr_bank_bench.sv
module evt_ctr_bank_bench;
  localparam int NP = 3;
  localparam int NC = 2 * NP;
  localparam logic [63:0] EN   = 64'h0000_0000_0040_0000;
  localparam logic [63:0] FUSE = 64'h0000_000F_0040_00FF;
  localparam logic [47:0] MAX48 = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NC*4-1:0] inc_i = '0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [NC-1:0] ovf_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_c [NC];
  logic [63:0] rv;

  always #4 clk = ~clk;

  evt_ctr_bank u_evt_ctr_bank (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_inc(input int n, input int v);
    inc_i[n*4 +: 4] = 4'(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R3: reset state and unmapped space
    for (int a = 0; a < 16; a++) begin
      rd(a, rv);
      if (a < 2 * NC) chk("R1 reset reg", rv, 64'h0);
      else            chk("R3 unmapped", rv, 64'h0);
    end
    chk("R1 ovf reset", 64'(ovf_o), 64'h0);

    // R2: control store and readback
    for (int n = 0; n < NC; n++) wr(2 * n, 64'h0123_4567_0089_AB00 + 64'(n));
    for (int n = 0; n < NC; n++) begin
      rd(2 * n, rv);
      chk("R2 ctl readback", rv, 64'h0123_4567_0089_AB00 + 64'(n));
    end
    wr(13, '1);
    rd(13, rv); chk("R3 unmapped write", rv, 64'h0);
    for (int a = 0; a < 2 * NC; a++) begin
      rd(a, rv);
      chk("R3 no side effect", rv, (a % 2 == 0) ? 64'h0123_4567_0089_AB00 + 64'(a / 2) : 64'h0);
    end

    // R4: independent counting sweep
    for (int n = 0; n < NC; n++) begin
      wr(2 * n, EN | 64'(n));
      exp_c[n] = 0;
    end
    for (int v = 0; v < 16; v++) begin
      int k;
      k = 1 + (v % 3);
      for (int n = 0; n < NC; n++) begin
        set_inc(n, (v + n) % 16);
        exp_c[n] += 64'(k * ((v + n) % 16));
      end
      repeat (k) @(negedge clk);
      inc_i = '0;
    end
    for (int n = 0; n < NC; n++) begin
      rd(2 * n + 1, rv); chk("R4 sweep count", rv, exp_c[n]);
    end
    wr(2, 64'h0);
    for (int n = 0; n < NC; n++) begin
      set_inc(n, 9);
      if (n != 1) exp_c[n] += 36;
    end
    repeat (4) @(negedge clk);
    inc_i = '0;
    for (int n = 0; n < NC; n++) begin
      rd(2 * n + 1, rv); chk("R4 disabled hold", rv, exp_c[n]);
    end
    chk("R9 no ovf yet", 64'(ovf_o), 64'h0);

    // R9: 48-bit wrap, even and odd counter
    wr(5, 64'(MAX48 - 48'd4));
    set_inc(2, 7); @(negedge clk); inc_i = '0;
    rd(5, rv); chk("R4 wrap value", rv, 64'd2);
    chk("R9 ovf set even", 64'(ovf_o), 64'h04);
    repeat (3) @(negedge clk);
    chk("R9 ovf sticky", 64'(ovf_o), 64'h04);
    wr(5, 64'h0);
    chk("R9 ovf cleared", 64'(ovf_o), 64'h0);
    wr(2, EN | 64'h1);
    wr(3, 64'(MAX48));
    set_inc(1, 1); @(negedge clk); inc_i = '0;
    chk("R9 ovf set odd", 64'(ovf_o), 64'h02);
    wr(3, 64'h0);
    chk("R9 odd cleared", 64'(ovf_o), 64'h0);

    // R6 / R7 / R8 / R9: fused pairs
    for (int p = 0; p < NP; p++) begin
      logic [63:0] ev;
      wr(4 * p + 2, FUSE);
      wr(4 * p, EN | 64'h3);
      wr(4 * p + 1, 64'h0);
      wr(4 * p + 3, 64'h0);
      ev = 0;
      for (int j = 0; j < 6; j++) begin
        int a, b;
        a = (p * 5 + j * 3) % 16;
        b = (j * 7 + p) % 16;
        set_inc(2 * p, a); set_inc(2 * p + 1, b);
        repeat (j + 1) @(negedge clk);
        inc_i = '0;
        ev += 64'((j + 1) * (b * 16 + a));
      end
      rd(4 * p + 1, rv); chk("R6 fused sum", rv, ev);
      rd(4 * p + 3, rv); chk("R6 odd not self-counting", rv, 64'h0);
      wr(4 * p + 1, 64'h0000_FFFF_FFFF_FFF0);
      wr(4 * p + 3, 64'h3);
      set_inc(2 * p + 1, 2); @(negedge clk); inc_i = '0;
      rd(4 * p + 1, rv); chk("R7 carry into high part", rv, 64'h0004_0000_0000_0010);
      rd(4 * p + 3, rv); chk("R8 odd holds high part", rv, 64'h4);
      chk("R9 no flag on 48-bit wrap fused", 64'(ovf_o), 64'h0);
      wr(4 * p + 1, 64'hFFFF_0000_0000_0042);
      rd(4 * p + 1, rv); chk("R8 even write keeps high", rv, 64'h0004_0000_0000_0042);
      wr(4 * p + 3, 64'hFFFF);
      wr(4 * p + 1, 64'(MAX48));
      set_inc(2 * p, 1); @(negedge clk); inc_i = '0;
      rd(4 * p + 1, rv); chk("R9 64-bit wrap value", rv, 64'h0);
      chk("R9 64-bit wrap flag", 64'(ovf_o), 64'(1) << (2 * p));
      wr(4 * p + 1, 64'h0);
      chk("R9 fused flag cleared", 64'(ovf_o), 64'h0);
      wr(4 * p, 64'h3);
      set_inc(2 * p, 5); set_inc(2 * p + 1, 5);
      repeat (3) @(negedge clk);
      inc_i = '0;
      rd(4 * p + 1, rv); chk("R6 primary enable gates", rv, 64'h0);
    end

    // R5: near-miss and fully set control words on pair 0
    wr(0, EN);
    wr(2, 64'h0000_000F_0000_00FF);
    wr(1, 64'h0); wr(3, 64'h0);
    set_inc(0, 3); set_inc(1, 5); repeat (4) @(negedge clk); inc_i = '0;
    rd(1, rv); chk("R5 no enable no fuse even", rv, 64'd12);
    rd(3, rv); chk("R5 no enable no fuse odd", rv, 64'd0);
    wr(2, 64'h0000_000E_0040_00FF);
    wr(1, 64'h0); wr(3, 64'h0);
    set_inc(0, 3); set_inc(1, 5); repeat (4) @(negedge clk); inc_i = '0;
    rd(1, rv); chk("R5 wrong nibble even", rv, 64'd12);
    rd(3, rv); chk("R5 wrong nibble odd", rv, 64'd20);
    wr(2, '1);
    wr(1, 64'h0); wr(3, 64'h0);
    set_inc(0, 3); set_inc(1, 5); repeat (2) @(negedge clk); inc_i = '0;
    rd(1, rv); chk("R5 other bits ignored", rv, 64'hA6);

    // R10: write and increment in the same cycle
    wr(2, EN | 64'h1);
    wr(1, 64'h0);
    @(negedge clk);
    set_inc(0, 5);
    reg_wr_en = 1'b1; reg_addr = 4'd1; reg_wdata = 64'd100;
    @(negedge clk);
    reg_wr_en = 1'b0; inc_i = '0;
    rd(1, rv); chk("R10 write wins", rv, 64'd100);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule